// File: doc/BRIEF.md
# Free-Running Timer with Dual Capture and Single Compare

This block is a 16-bit timebase for event timing and waveform generation. A counter advances on every cycle in which the tick enable is high. It wraps from all-ones to zero. Each wrap raises a sticky overflow flag, and that flag can request an interrupt.

Two capture channels watch asynchronous input pins. Each pin passes through a synchronizer. When a channel sees its chosen edge, it copies the counter into its capture register and sets its own sticky flag. A software control bit per channel picks the edge: rising or falling. These edge choices survive reset.

One compare channel compares the counter with a programmed value. On a match it loads a programmed level into a private output level register. That register drives the compare pin only while the output enable is set. Otherwise the pin sits at 0.

Control is a set of write strobes with data; address decoding lives outside the block.

Top module: `capcmp_timer`

## Requirements
- R1: Reset sets `count` to 0. Outside reset, `count` increments by one on each clock edge where `tick_en` is high, holds otherwise, and wraps from 16'hFFFF to 16'h0000.
- R2: A wrap (`tick_en` high with `count` at 16'hFFFF) sets `ovf_flag` at that edge. The flag stays set until an edge with `ovf_clr` high and no wrap; when both occur in the same cycle, the flag is set. Reset clears it.
- R3: `ovf_irq` equals `ovf_flag` while the overflow interrupt enable (control bit 0) is 1, and is 0 while that bit is 0.
- R4: A write with `ctl_we` high loads the control fields from `ctl_wdata` as follows. Bit 0 is the overflow interrupt enable. Bit 1 is the compare output enable. Bit 2 is the edge select for channel 0. Bit 3 is the edge select for channel 1. Bit 4 is the output level. Reset clears bits 0, 1 and 4.
- R5: Reset leaves the two edge select bits unchanged. This includes a value written with `ctl_we` during reset.
- R6: Capture channel i sees its selected edge on `cap_pin[i]`: rising when its edge select is 1, falling when it is 0. The channel then sets `cap_flag[i]` on the third rising clock edge after the pin changes. At that same edge it loads into its slice of `cap_vals` the `count` value of the preceding cycle. Slice i is bits [16*i+15:16*i].
- R7: `cap_flag[i]` is sticky and clears on an edge with `cap_clr[i]` high, unless a new capture occurs in that cycle, which keeps it set. A capture register changes only on a capture. Reset clears both flags and both registers.
- R8: A compare match is a cycle in which `count` equals the compare register, except the cycle right after a write with `cmp_we` high. The compare register resets to 16'hFFFF and loads `cmp_wdata` on a write.
- R9: At the edge ending a match cycle, the output level register takes the output level bit. It holds in all other cycles. Reset clears it.
- R10: `cmp_pin` equals the output level register while the compare output enable is 1, and is 0 while it is 0. The register keeps updating on matches whatever the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance enable |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data (fields per R4) |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 16 | Compare register write data |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| cap_clr | input | 2 | Per-channel capture flag clear strobes |
| cap_pin | input | 2 | Asynchronous capture inputs |
| count | output | 16 | Current counter value |
| cap_vals | output | 32 | Capture registers, channel i at [16*i+15:16*i] |
| cap_flag | output | 2 | Sticky capture flags |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |
| cmp_pin | output | 1 | Gated compare output |

## Verification
The bench targets four kinds of error.

Edge selects written during reset must survive it. A design that resets them would capture on the wrong edge or miss the edge entirely.

Compare writes are aimed a few counts ahead of the counter. This produces matches in the inhibited cycle right after a write, where a design without the inhibit would load the output level one cycle early.

The output enable is toggled while matches occur. This exposes a design that freezes the level register while the pin is gated, or that lets the pin float away from 0.

Long runs cover a counter wrap with set and clear arriving in the same cycle. They also cover capture flags cleared in the cycle a new capture lands, where a wrong priority would drop the event.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_W    = 16;
    localparam int TMR_NCAP = 2;

    // Control word; ovf_ie sits at bit 0.
    typedef struct packed {
        logic out_lvl;   // bit 4
        logic edge1_up;  // bit 3
        logic edge0_up;  // bit 2
        logic cmp_oe;    // bit 1
        logic ovf_ie;    // bit 0
    } ctl_t;

    function automatic logic edge_hit(input logic rise_sel, input logic cur, input logic prev);
        return rise_sel ? (cur & ~prev) : (~cur & prev);
    endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         ovf_clr,
    output logic [W-1:0] cnt,
    output logic         ovf_flag
);
    localparam logic [W-1:0] TOP = '1;

    logic wrap;
    assign wrap = tick_en && (cnt == TOP);

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (tick_en) cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          ovf_flag <= 1'b0;
        else if (wrap)    ovf_flag <= 1'b1;
        else if (ovf_clr) ovf_flag <= 1'b0;
    end

    p_cnt_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(cnt));
    p_wrap_zero_r1: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0));
    p_wrap_sets_ovf_r2: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ovf_flag);
    p_ovf_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
    parameter int W    = 16,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pin,
    input  logic         rise_sel,
    input  logic         clr,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] val,
    output logic         flag
);
    logic [SYNC-1:0] sreg;
    logic            prev;
    logic            hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            prev <= 1'b0;
        end else begin
            sreg <= {sreg[SYNC-2:0], pin};
            prev <= sreg[SYNC-1];
        end
    end

    assign hit = tmr_pkg::edge_hit(rise_sel, sreg[SYNC-1], prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            val  <= '0;
            flag <= 1'b0;
        end else if (hit) begin
            val  <= cnt;
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    p_cap_val_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(val));
    p_cap_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
    p_cap_loads_r6: assert property (@(posedge clk) disable iff (rst)
        hit |=> (flag && val == $past(cnt)));
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         lvl,
    input  logic         oe,
    output logic         cmp_pin
);
    logic [W-1:0] cmp_q;
    logic         blk;
    logic         olr;
    logic         match;

    assign match = (cnt == cmp_q) && !blk;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '1;
            blk   <= 1'b0;
        end else begin
            blk <= cmp_we;
            if (cmp_we) cmp_q <= cmp_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        olr <= 1'b0;
        else if (match) olr <= lvl;
    end

    assign cmp_pin = oe & olr;

    p_olr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !match |=> $stable(olr));
    p_write_inhibit_r8: assert property (@(posedge clk) disable iff (rst)
        cmp_we |=> ##1 $stable(olr));
    p_olr_load_r9: assert property (@(posedge clk) disable iff (rst)
        match |=> (olr == $past(lvl)));
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
    import tmr_pkg::*;
#(
    parameter int W    = TMR_W,
    parameter int NCAP = TMR_NCAP,
    parameter int SYNC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_en,
    input  logic            ctl_we,
    input  logic [4:0]      ctl_wdata,
    input  logic            cmp_we,
    input  logic [W-1:0]    cmp_wdata,
    input  logic            ovf_clr,
    input  logic [NCAP-1:0] cap_clr,
    input  logic [NCAP-1:0] cap_pin,
    output logic [W-1:0]    count,
    output logic [NCAP*W-1:0] cap_vals,
    output logic [NCAP-1:0] cap_flag,
    output logic            ovf_flag,
    output logic            ovf_irq,
    output logic            cmp_pin
);
    ctl_t            wr;
    logic            ovf_ie_q, cmp_oe_q, lvl_q;
    logic [NCAP-1:0] edge_q;

    assign wr = ctl_t'(ctl_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_ie_q <= 1'b0;
            cmp_oe_q <= 1'b0;
            lvl_q    <= 1'b0;
        end else if (ctl_we) begin
            ovf_ie_q <= wr.ovf_ie;
            cmp_oe_q <= wr.cmp_oe;
            lvl_q    <= wr.out_lvl;
        end
    end

    // Edge selects deliberately have no reset branch.
    always_ff @(posedge clk) begin
        if (ctl_we) edge_q <= {wr.edge1_up, wr.edge0_up};
    end

    tmr_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .tick_en(tick_en), .ovf_clr(ovf_clr),
        .cnt(count), .ovf_flag(ovf_flag)
    );

    assign ovf_irq = ovf_flag & ovf_ie_q;

    for (genvar i = 0; i < NCAP; i++) begin : g_cap
        tmr_capture #(.W(W), .SYNC(SYNC)) u_cap (
            .clk(clk), .rst(rst), .pin(cap_pin[i]), .rise_sel(edge_q[i]),
            .clr(cap_clr[i]), .cnt(count),
            .val(cap_vals[i*W +: W]), .flag(cap_flag[i])
        );
    end

    tmr_compare #(.W(W)) u_cmp (
        .clk(clk), .rst(rst), .cnt(count), .cmp_we(cmp_we),
        .cmp_wdata(cmp_wdata), .lvl(lvl_q), .oe(cmp_oe_q), .cmp_pin(cmp_pin)
    );

    p_edge_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ctl_we |=> $stable(edge_q));
    p_irq_follows_r3: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr && !ctl_we && ovf_ie_q) |=> ovf_irq);
    p_ctl_load_r4: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (cmp_oe_q == $past(wr.cmp_oe)));
endmodule

// File: tb/capcmp_timer_tb.sv
module capcmp_timer_tb_top;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          tick_en, ctl_we, cmp_we, ovf_clr;
    logic [4:0]    ctl_wdata;
    logic [W-1:0]  cmp_wdata;
    logic [1:0]    cap_clr, cap_pin;
    logic [W-1:0]  count;
    logic [2*W-1:0] cap_vals;
    logic [1:0]    cap_flag;
    logic          ovf_flag, ovf_irq, cmp_pin;

    int n_chk = 0;
    int n_fail = 0;
    bit chk_on = 1'b0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    capcmp_timer dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .ovf_clr(ovf_clr), .cap_clr(cap_clr), .cap_pin(cap_pin),
        .count(count), .cap_vals(cap_vals), .cap_flag(cap_flag),
        .ovf_flag(ovf_flag), .ovf_irq(ovf_irq), .cmp_pin(cmp_pin)
    );

    // Reference model built from the requirements
    logic [W-1:0] m_cnt, m_cmp;
    logic         m_ovf, m_ie, m_oe, m_lvl, m_blk, m_olr;
    logic [1:0]   m_esel, m_s1, m_s2, m_s3, m_cf;
    logic [W-1:0] m_cap [2];

    function automatic logic m_hit(input logic sel, input logic c, input logic p);
        if (sel) return c && !p;
        return !c && p;
    endfunction

    always @(posedge clk) begin
        if (ctl_we) m_esel <= ctl_wdata[3:2];                 // R5
        if (rst) begin
            m_cnt <= '0; m_ovf <= 0; m_ie <= 0; m_oe <= 0; m_lvl <= 0;
            m_cmp <= '1; m_blk <= 0; m_olr <= 0;
            m_s1 <= 0; m_s2 <= 0; m_s3 <= 0; m_cf <= 0;
            m_cap[0] <= '0; m_cap[1] <= '0;
        end else begin
            if (ctl_we) begin
                m_ie <= ctl_wdata[0]; m_oe <= ctl_wdata[1]; m_lvl <= ctl_wdata[4];
            end
            if (tick_en) m_cnt <= m_cnt + 1'b1;
            if (tick_en && m_cnt == '1) m_ovf <= 1;
            else if (ovf_clr) m_ovf <= 0;
            if (m_cnt == m_cmp && !m_blk) m_olr <= m_lvl;
            m_blk <= cmp_we;
            if (cmp_we) m_cmp <= cmp_wdata;
            m_s1 <= cap_pin; m_s2 <= m_s1; m_s3 <= m_s2;
            for (int i = 0; i < 2; i++) begin
                if (m_hit(m_esel[i], m_s2[i], m_s3[i])) begin
                    m_cap[i] <= m_cnt; m_cf[i] <= 1;
                end else if (cap_clr[i]) m_cf[i] <= 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (chk_on) begin
            chk("R1 count", 32'(count), 32'(m_cnt));
            chk("R2 ovf_flag", 32'(ovf_flag), 32'(m_ovf));
            chk("R3 ovf_irq", 32'(ovf_irq), 32'(m_ovf & m_ie));
            chk("R6 cap0", 32'(cap_vals[W-1:0]), 32'(m_cap[0]));
            chk("R6 cap1", 32'(cap_vals[2*W-1:W]), 32'(m_cap[1]));
            chk("R7 cap_flag", 32'(cap_flag), 32'(m_cf));
            chk("R10 cmp_pin", 32'(cmp_pin), 32'(m_oe ? m_olr : 1'b0));
        end
        if (cyc > 190000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ctl_we = 0; cmp_we = 0; ovf_clr = 0; cap_clr = 0;
        end
    endtask

    initial begin
        void'($urandom(32'd1357));
        rst = 1; tick_en = 0; ctl_we = 1; ctl_wdata = 5'b01100; // both rising
        cmp_we = 0; cmp_wdata = '0; ovf_clr = 0; cap_clr = 0; cap_pin = 0;
        @(negedge clk); ctl_we = 0;
        @(negedge clk);
        chk_on = 1;
        @(negedge clk);
        chk("R1 reset count", 32'(count), 32'd0);
        chk("R4 reset irq/pin", {30'd0, ovf_irq, cmp_pin}, 32'd0);
        chk("R7 reset flags", 32'(cap_flag), 32'd0);
        rst = 0; tick_en = 1;
        idle(5);
        // R5: pulse reset again without a write; rising selects must persist
        rst = 1; idle(2); rst = 0;
        idle(3);
        cap_pin = 2'b01;
        idle(4);
        chk("R5 edge kept through reset", 32'(cap_flag[0]), 32'd1);
        // R6: falling edge on channel 1 after selecting falling
        ctl_we = 1; ctl_wdata = 5'b00100; idle(1);
        cap_pin = 2'b11; idle(5); cap_clr = 2'b11; idle(1);
        cap_pin = 2'b01; idle(4);
        chk("R6 falling capture ch1", 32'(cap_flag[1]), 32'd1);
        // R10/R9: match with output disabled, then enable
        ctl_we = 1; ctl_wdata = 5'b10100; idle(1);
        cmp_we = 1; cmp_wdata = count + 16'd4; idle(8);
        chk("R10 gated pin idle", 32'(cmp_pin), 32'd0);
        ctl_we = 1; ctl_wdata = 5'b00110; idle(2);
        chk("R9 level loaded while gated", 32'(cmp_pin), 32'd1);
        // Random phase
        for (int k = 0; k < 120000; k++) begin
            @(negedge clk);
            tick_en   = ($urandom % 10) != 0;
            ctl_we    = ($urandom % 97) == 0;
            ctl_wdata = 5'($urandom);
            cmp_we    = ($urandom % 13) == 0;
            cmp_wdata = count + 16'($urandom % 4);
            ovf_clr   = ($urandom % 2000) == 0;
            cap_clr   = (($urandom % 11) == 0) ? 2'($urandom) : 2'b00;
            if (($urandom % 5) == 0) cap_pin = 2'($urandom);
        end
        idle(6);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule